// File: doc/BRIEF.md
# DMA Transfer Request Activation Controller

This block sits in front of the data mover of one DMA channel. It decides when the channel may begin a transfer unit, emits a one-cycle start strobe for that unit, and holds a bus-hold flag while the channel owns the bus. Requests come from one of two sources. In self-triggered mode the channel starts units for as long as it is enabled. In pin mode it waits for an active-low request pin, which can be sensed either on its falling edge or as a sustained low level.

Software-style control arrives as an enable-set strobe, which also loads a transfer count, and an enable-clear strobe. The mover reports the end of each unit with a one-cycle done strobe. Each done decrements the count. When the count runs out, the channel disables itself and raises a one-cycle end-of-transfer pulse. An optional active-low acknowledge pulse marks each pin request that is accepted, and it coincides with the start strobe.

Top module: `dma_act_ctrl`

## Requirements
- R1: After reset, start_o, bus_hold_o, eot_o and chan_en_o are 0 and ack_no is 1.
- R2: An en_set_i pulse with a nonzero xfer_cnt_i loads the count and sets chan_en_o in the next cycle. A pulse with a zero count leaves the channel disabled. A pulse that arrives while a unit is in flight is ignored.
- R3: With src_sel_i=0 (self-triggered), the first start_o pulse appears in the second clock cycle after the cycle in which en_set_i is sampled. Every start_o pulse is exactly one cycle long. The next unit starts one cycle after each done_i, until the count is used up.
- R4: With src_sel_i=1 and sense_lvl_i=1, units start only while the request pin, after a two-flop synchronizer, is low. No unit starts while the pin is high.
- R5: With src_sel_i=1 and sense_lvl_i=0, each falling edge of the pin yields exactly one unit, and a pin held low yields only one. An edge that arrives during a unit is remembered and served once that unit ends.
- R6: ack_no goes low for exactly the cycles in which start_o is 1, and only when ack_en_i=1 and src_sel_i=1. In every other case it stays high.
- R7: With burst_i=0, bus_hold_o is 1 from the start_o cycle through the cycle in which done_i is sampled, and it is 0 between units.
- R8: With burst_i=1 and src_sel_i=0, bus_hold_o stays 1 from the first start_o until the last done_i. In pin mode burst_i has no effect and R7 applies.
- R9: Each done_i during a unit decrements the count. The done_i that brings the count to zero clears chan_en_o and raises eot_o for one cycle, and no further unit starts.
- R10: An en_clr_i pulse during a unit lets that unit finish, with bus_hold_o dropping after its done_i. No new unit starts after it, eot_o is not raised, and a falling edge that was pending is discarded.
- R11: A done_i pulse while no unit is in flight leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_set_i | input | 1 | Enable the channel and load the count |
| en_clr_i | input | 1 | Disable the channel |
| xfer_cnt_i | input | CNT_W | Number of units to run, loaded on en_set_i |
| src_sel_i | input | 1 | 0 = self-triggered, 1 = request pin |
| sense_lvl_i | input | 1 | 0 = falling-edge sensing, 1 = low-level sensing |
| ack_en_i | input | 1 | Enables the acknowledge pulse |
| burst_i | input | 1 | 0 = release the bus after each unit, 1 = hold it to the end |
| req_ni | input | 1 | External request pin, active low, asynchronous |
| done_i | input | 1 | End-of-unit strobe from the mover |
| start_o | output | 1 | Unit start strobe |
| bus_hold_o | output | 1 | Channel holds the bus |
| ack_no | output | 1 | Acknowledge pulse, active low |
| eot_o | output | 1 | End-of-transfer pulse |
| chan_en_o | output | 1 | Current channel enable state |

## Verification
The embedded properties assume that src_sel_i, sense_lvl_i, burst_i and ack_en_i do not change while the channel is enabled or a unit is in flight, and that done_i is a single-cycle pulse. The stimulus changes these configuration inputs only while the channel is disabled and idle. The modelled mover raises done_i exactly once per observed start, after a random delay, and stray done_i pulses are injected only while no unit is open. Falling edges are spaced more than two cycles apart so that the synchronizer sees each one.

// File: rtl/dma_act_pkg.sv
package dma_act_pkg;

   typedef enum logic {
      SRC_SELF = 1'b0,
      SRC_PIN  = 1'b1
   } src_e;

   localparam int unsigned MIN_SYNC = 2;

endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_ni,
   output logic low_o,
   output logic fall_o
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < dma_act_pkg::MIN_SYNC) begin : g_bad_stages
      $error("dma_req_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[0] <= 1'b1;
            else         chain_q[0] <= pin_ni;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[i] <= 1'b1;
            else         chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b1;
      else         prev_q <= chain_q[LAST];
   end

   assign low_o  = ~chain_q[LAST];
   assign fall_o = prev_q & ~chain_q[LAST];

   // R5: a detected edge is never reported in two consecutive cycles
   p_fall_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |=> !fall_o);

endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual
   import dma_act_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  src_e src_i,
   input  logic sense_lvl_i,
   input  logic low_i,
   input  logic fall_i,
   input  logic accept_i,
   output logic req_ok_o
);
   logic pend_q;
   logic pend_d;
   logic pin_mode;
   logic edge_arm;

   assign pin_mode = (src_i == SRC_PIN);
   assign edge_arm = en_i & pin_mode & ~sense_lvl_i;

   always_comb begin
      pend_d = pend_q & ~accept_i & en_i;
      if (fall_i && edge_arm) pend_d = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= pend_d;
   end

   always_comb begin
      if (!pin_mode)        req_ok_o = 1'b1;
      else if (sense_lvl_i) req_ok_o = low_i;
      else                  req_ok_o = pend_q;
   end

   // R10: a pending edge does not survive a disabled channel
   p_pend_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !pend_q);

   // R5: an accepted edge is consumed unless a fresh edge arrives with it
   p_pend_consumed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accept_i && pin_mode && !sense_lvl_i && !fall_i) |=> !pend_q);

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
   import dma_act_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_set_i,
   input  logic             en_clr_i,
   input  logic [CNT_W-1:0] cnt_load_i,
   input  src_e             src_i,
   input  logic             ack_en_i,
   input  logic             burst_i,
   input  logic             req_ok_i,
   input  logic             done_i,
   output logic             accept_o,
   output logic             en_o,
   output logic             start_o,
   output logic             hold_o,
   output logic             ack_no,
   output logic             eot_o
);
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ZERO = '0;

   logic             en_q;
   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic             start_q;
   logic             hold_q;
   logic             ack_q;
   logic             eot_q;

   logic accept;
   logic unit_end;
   logic last_unit;
   logic load_ok;
   logic keep_bus;
   logic release_bus;

   assign accept      = en_q & ~busy_q & req_ok_i;
   assign unit_end    = busy_q & done_i;
   assign last_unit   = (cnt_q == ONE);
   assign load_ok     = en_set_i & ~en_clr_i & ~busy_q & (cnt_load_i != ZERO);
   assign keep_bus    = burst_i & (src_i == SRC_SELF);
   assign release_bus = unit_end & (~keep_bus | last_unit | ~en_q | en_clr_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q    <= 1'b0;
         busy_q  <= 1'b0;
         cnt_q   <= ZERO;
         start_q <= 1'b0;
         hold_q  <= 1'b0;
         ack_q   <= 1'b0;
         eot_q   <= 1'b0;
      end else begin
         start_q <= accept;
         ack_q   <= accept & ack_en_i & (src_i == SRC_PIN);
         eot_q   <= unit_end & last_unit & en_q;

         if (accept)        busy_q <= 1'b1;
         else if (unit_end) busy_q <= 1'b0;

         if (unit_end)     cnt_q <= cnt_q - ONE;
         else if (load_ok) cnt_q <= cnt_load_i;

         if (en_clr_i || (unit_end && last_unit)) en_q <= 1'b0;
         else if (load_ok)                        en_q <= 1'b1;

         if (accept)                 hold_q <= 1'b1;
         else if (release_bus)       hold_q <= 1'b0;
         else if (!busy_q && !en_q)  hold_q <= 1'b0;
      end
   end

   assign accept_o = accept;
   assign en_o     = en_q;
   assign start_o  = start_q;
   assign hold_o   = hold_q;
   assign ack_no   = ~ack_q;
   assign eot_o    = eot_q;

   // R3: start strobes are single-cycle
   p_start_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_q |=> !start_q);

   // R2: a unit only starts from an enabled channel
   p_start_needs_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_q |-> $past(en_q));

   // R6: acknowledge never appears without a start strobe
   p_ack_with_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ack_no |-> start_q);

   // R7: the bus is held whenever a unit is in flight
   p_busy_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_q |-> hold_q);

   // R9: end of transfer leaves the channel disabled
   p_eot_disables_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eot_q |-> !en_q);

   // R9: an enabled channel always has units left
   p_cnt_live_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_q |-> (cnt_q != ZERO));

endmodule

// File: rtl/dma_act_ctrl.sv
module dma_act_ctrl
   import dma_act_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_set_i,
   input  logic             en_clr_i,
   input  logic [CNT_W-1:0] xfer_cnt_i,
   input  logic             src_sel_i,
   input  logic             sense_lvl_i,
   input  logic             ack_en_i,
   input  logic             burst_i,
   input  logic             req_ni,
   input  logic             done_i,
   output logic             start_o,
   output logic             bus_hold_o,
   output logic             ack_no,
   output logic             eot_o,
   output logic             chan_en_o
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("dma_act_ctrl: CNT_W must be at least 2");
   end

   src_e src;
   logic pin_low;
   logic pin_fall;
   logic req_ok;
   logic accept;
   logic en;

   assign src = src_e'(src_sel_i);

   dma_req_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_ni (req_ni),
      .low_o  (pin_low),
      .fall_o (pin_fall)
   );

   dma_req_qual u_qual (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en),
      .src_i       (src),
      .sense_lvl_i (sense_lvl_i),
      .low_i       (pin_low),
      .fall_i      (pin_fall),
      .accept_i    (accept),
      .req_ok_o    (req_ok)
   );

   dma_xfer_seq #(
      .CNT_W (CNT_W)
   ) u_seq (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_set_i   (en_set_i),
      .en_clr_i   (en_clr_i),
      .cnt_load_i (xfer_cnt_i),
      .src_i      (src),
      .ack_en_i   (ack_en_i),
      .burst_i    (burst_i),
      .req_ok_i   (req_ok),
      .done_i     (done_i),
      .accept_o   (accept),
      .en_o       (en),
      .start_o    (start_o),
      .hold_o     (bus_hold_o),
      .ack_no     (ack_no),
      .eot_o      (eot_o)
   );

   assign chan_en_o = en;

   // R1: acknowledge is idle out of reset and whenever no strobe is seen
   p_ack_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !start_o |-> ack_no);

endmodule

// File: tb/dma_act_ctrl_tb.sv
module dma_act_ctrl_tb_top;

   localparam int CW = 16;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic          en_set_i = 1'b0;
   logic          en_clr_i = 1'b0;
   logic [CW-1:0] xfer_cnt_i = '0;
   logic          src_sel_i = 1'b0;
   logic          sense_lvl_i = 1'b0;
   logic          ack_en_i = 1'b0;
   logic          burst_i = 1'b0;
   logic          req_ni = 1'b1;
   logic          done_i;
   logic          start_o, bus_hold_o, ack_no, eot_o, chan_en_o;

   logic mv_done = 1'b0;
   logic st_done = 1'b0;
   assign done_i = mv_done | st_done;

   always #10 clk_i = ~clk_i;

   dma_act_ctrl #(.CNT_W(CW), .SYNC_STAGES(2)) dut_i (
      .clk_i, .rst_ni, .en_set_i, .en_clr_i, .xfer_cnt_i, .src_sel_i,
      .sense_lvl_i, .ack_en_i, .burst_i, .req_ni, .done_i,
      .start_o, .bus_hold_o, .ack_no, .eot_o, .chan_en_o
   );

   int n_vec = 0;
   int n_bad = 0;
   int mover_delay = 0;

   int n_start, n_ack, n_eot, units, exp_units;
   int hold_err, ack_err, overlap_err;
   bit inflight, inburst, hold_chk, burst_exp, ack_exp;

   task automatic check(string req, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic bit exp_burst(bit ext, bit bst);
      return bst && !ext;
   endfunction

   function automatic bit exp_ack(bit ext, bit ack);
      return ext && ack;
   endfunction

   task automatic cyc();
      @(negedge clk_i);
   endtask

   task automatic mover();
      bit waiting = 0;
      int dly = 0;
      forever begin
         @(negedge clk_i);
         mv_done = 1'b0;
         if (waiting) begin
            if (dly == 0) begin
               mv_done = 1'b1;
               waiting = 0;
            end else dly--;
         end
         if (start_o) begin
            waiting = 1;
            dly = mover_delay;
         end
      end
   endtask

   task automatic monitor();
      bit exp_h;
      forever begin
         @(negedge clk_i);
         #1;
         if (!rst_ni) continue;
         if (start_o) begin
            n_start++;
            if (inflight) overlap_err++;
            inflight = 1;
            inburst = 1;
            if (ack_no !== !ack_exp) ack_err++;
            if (!ack_no) n_ack++;
         end else if (!ack_no) ack_err++;
         if (eot_o) n_eot++;
         exp_h = burst_exp ? inburst : inflight;
         if (hold_chk && (bus_hold_o !== exp_h)) hold_err++;
         if (done_i && inflight) begin
            units++;
            inflight = 0;
            if (units >= exp_units) inburst = 0;
         end
      end
   endtask

   task automatic mon_clear(int n, bit bexp, bit aexp, bit hchk);
      n_start = 0; n_ack = 0; n_eot = 0; units = 0; exp_units = n;
      hold_err = 0; ack_err = 0; overlap_err = 0;
      inflight = 0; inburst = 0;
      burst_exp = bexp; ack_exp = aexp; hold_chk = hchk;
   endtask

   task automatic configure(bit ext, bit lvl, bit ack, bit bst, int dly);
      cyc();
      src_sel_i = ext; sense_lvl_i = lvl; ack_en_i = ack; burst_i = bst;
      mover_delay = dly;
   endtask

   task automatic enable(int n);
      cyc();
      en_set_i = 1'b1; xfer_cnt_i = CW'(n);
      cyc();
      en_set_i = 1'b0;
   endtask

   task automatic pulse_edge();
      req_ni = 1'b0;
      repeat (3) cyc();
      req_ni = 1'b1;
      repeat (3) cyc();
   endtask

   task automatic wait_units(int target);
      for (int i = 0; i < 400; i++) begin
         if (units >= target) break;
         cyc();
      end
   endtask

   task automatic wait_eot();
      for (int i = 0; i < 3000; i++) begin
         if (n_eot > 0) break;
         cyc();
      end
   endtask

   task automatic run_job(bit ext, bit lvl, bit ack, bit bst, int n, int dly, string tag);
      configure(ext, lvl, ack, bst, dly);
      mon_clear(n, exp_burst(ext, bst), exp_ack(ext, ack), 1);
      enable(n);
      if (ext && lvl) req_ni = 1'b0;
      if (ext && !lvl) begin
         for (int k = 0; k < n; k++) begin
            pulse_edge();
            wait_units(k + 1);
         end
      end
      wait_eot();
      req_ni = 1'b1;
      repeat (6) cyc();
      #2;
      check({tag, " R9 unit count"}, n_start, n);
      check({tag, " R9 eot pulses"}, n_eot, 1);
      check({tag, " R9 enable cleared"}, int'(chan_en_o), 0);
      check({tag, " R6 ack count"}, n_ack, exp_ack(ext, ack) ? n : 0);
      check({tag, " R6 ack alignment"}, ack_err, 0);
      check({tag, bst ? " R8 burst hold" : " R7 bus hold"}, hold_err, 0);
      check({tag, " R3 no overlap"}, overlap_err, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk_i);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0a17));
      mon_clear(0, 0, 0, 0);
      fork
         mover();
         monitor();
      join_none

      repeat (3) cyc();
      // R1: reset state
      check("R1 start", int'(start_o), 0);
      check("R1 hold", int'(bus_hold_o), 0);
      check("R1 ack_n", int'(ack_no), 1);
      check("R1 eot", int'(eot_o), 0);
      check("R1 enable", int'(chan_en_o), 0);
      rst_ni = 1'b1;
      repeat (2) cyc();

      // R2: zero count leaves channel off
      configure(0, 0, 0, 0, 1);
      mon_clear(0, 0, 0, 1);
      enable(0);
      repeat (10) cyc();
      #2;
      check("R2 zero count enable", int'(chan_en_o), 0);
      check("R2 zero count starts", n_start, 0);

      // R3: exact latency of self-triggered start
      configure(0, 0, 0, 0, 0);
      mon_clear(3, 0, 0, 1);
      cyc();
      en_set_i = 1'b1; xfer_cnt_i = 16'd3;
      cyc();
      en_set_i = 1'b0;
      check("R2 enable next cycle", int'(chan_en_o), 1);
      check("R3 no start yet", int'(start_o), 0);
      cyc();
      check("R3 start second cycle", int'(start_o), 1);
      cyc();
      check("R3 single cycle strobe", int'(start_o), 0);
      wait_eot();
      repeat (4) cyc();
      #2;
      check("R3 units", n_start, 3);
      check("R7 hold model", hold_err, 0);
      check("R6 ack quiet self mode", n_ack, 0);

      // R2: reload ignored while unit in flight
      configure(0, 0, 0, 0, 10);
      mon_clear(2, 0, 0, 1);
      enable(2);
      repeat (4) cyc();
      en_set_i = 1'b1; xfer_cnt_i = 16'd9;
      cyc();
      en_set_i = 1'b0;
      wait_eot();
      repeat (4) cyc();
      #2;
      check("R2 reload ignored busy", n_start, 2);

      // R4: level sensing, no start while pin high
      configure(1, 1, 1, 0, 1);
      mon_clear(3, 0, 1, 1);
      enable(3);
      repeat (12) cyc();
      #2;
      check("R4 pin high no start", n_start, 0);
      req_ni = 1'b0;
      wait_eot();
      req_ni = 1'b1;
      repeat (4) cyc();
      #2;
      check("R4 level units", n_start, 3);
      check("R6 ack per unit", n_ack, 3);

      // R5: held-low pin gives one unit
      configure(1, 0, 0, 0, 1);
      mon_clear(3, 0, 0, 1);
      enable(3);
      req_ni = 1'b0;
      repeat (30) cyc();
      #2;
      check("R5 held low one unit", n_start, 1);
      check("R5 enable kept", int'(chan_en_o), 1);
      req_ni = 1'b1;
      cyc();
      en_clr_i = 1'b1;
      cyc();
      en_clr_i = 1'b0;
      repeat (4) cyc();

      // R5: edge during a unit is served after it
      configure(1, 0, 0, 0, 15);
      mon_clear(5, 0, 0, 1);
      enable(5);
      pulse_edge();
      pulse_edge();
      repeat (50) cyc();
      #2;
      check("R5 pending edge served", n_start, 2);
      cyc();
      en_clr_i = 1'b1;
      cyc();
      en_clr_i = 1'b0;
      repeat (4) cyc();

      // R10: pending edge discarded on clear
      configure(1, 0, 0, 0, 15);
      mon_clear(5, 0, 0, 1);
      enable(5);
      pulse_edge();
      pulse_edge();
      cyc();
      en_clr_i = 1'b1;
      cyc();
      en_clr_i = 1'b0;
      repeat (30) cyc();
      enable(5);
      repeat (20) cyc();
      #2;
      check("R10 pending edge dropped", n_start, 1);
      pulse_edge();
      repeat (25) cyc();
      #2;
      check("R5 new edge after reenable", n_start, 2);
      cyc();
      en_clr_i = 1'b1;
      cyc();
      en_clr_i = 1'b0;
      repeat (20) cyc();

      // R10: clear during a burst unit
      configure(0, 0, 0, 1, 8);
      mon_clear(5, 0, 0, 0);
      enable(5);
      repeat (4) cyc();
      check("R8 hold in unit", int'(bus_hold_o), 1);
      en_clr_i = 1'b1;
      cyc();
      en_clr_i = 1'b0;
      check("R10 hold kept to done", int'(bus_hold_o), 1);
      repeat (30) cyc();
      #2;
      check("R10 no new unit", n_start, 1);
      check("R10 hold released", int'(bus_hold_o), 0);
      check("R10 enable off", int'(chan_en_o), 0);
      check("R10 no eot", n_eot, 0);

      // R11: stray done while idle
      configure(1, 1, 1, 0, 2);
      mon_clear(2, 0, 1, 1);
      enable(2);
      for (int k = 0; k < 3; k++) begin
         cyc(); st_done = 1'b1;
         cyc(); st_done = 1'b0;
      end
      req_ni = 1'b0;
      wait_eot();
      req_ni = 1'b1;
      repeat (6) cyc();
      #2;
      check("R11 stray done ignored", n_start, 2);

      // R8: burst ignored in pin mode
      run_job(1, 1, 0, 1, 3, 2, "pin-burst");
      // R8: burst in self mode
      run_job(0, 0, 0, 1, 4, 1, "self-burst");

      for (int j = 0; j < 24; j++) begin
         bit ext = 1'($urandom_range(0, 1));
         bit lvl = 1'($urandom_range(0, 1));
         bit ack = 1'($urandom_range(0, 1));
         bit bst = 1'($urandom_range(0, 1));
         int n   = int'($urandom_range(1, 6));
         int dly = int'($urandom_range(0, 3));
         run_job(ext, lvl, ack, bst, n, dly, $sformatf("rnd%0d", j));
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule